// File: doc/BRIEF.md
# Deferred Interrupt Holding Buffer

When interrupts are switched off while an external interrupt is already travelling down the pipeline, the flush logic removes that interrupt before it can commit. This block keeps such interrupts so that none is lost. Each entry holds three fields: the interrupt's identity, its priority, and the address of the instruction it interrupted. That address is the restart point. No separate jump target is kept. Several entries can be held at once, because more than one interrupt may be in flight when the flush happens.

Once the global interrupt enable is set again, the buffer offers its entries to fetch one at a time through a valid/ready handshake. A mode input selects the order in which entries come back. Queue order replays interrupts in the order they occurred. Stack order replays the most recent first, and in this mode a new entry is taken only if it outranks the current top. This mirrors nesting, where only a higher priority can preempt a lower one. A refused entry is reported back so the requester can keep it pending.

Top module: `deferred_irq_buffer`

## Requirements
- R1: After reset, `empty` is 1 and `full`, `overflow`, `popValid` and `pushReject` are 0.
- R2: A popped entry presents exactly the identity, priority and restart address that were pushed for it.
- R3: With `modeStack`=0 (queue order), entries are popped in the order they were accepted.
- R4: With `modeStack`=1 (stack order), entries are popped most recent first.
- R5: In stack order with a non-empty buffer, a push whose priority is not strictly greater than the top entry's priority is refused. `pushReject` is 1 combinationally in that cycle and nothing is stored. In queue order, `pushReject` is never 1.
- R6: `popValid` is 1 only while `intEnable`=1 and the buffer is non-empty. An entry is removed only in a cycle with `popValid` and `popReady` both 1, and at most one entry is removed per cycle.
- R7: `full` is 1 exactly when DEPTH entries are held, and `empty` is 1 exactly when none are held.
- R8: A push that is not refused by priority and arrives while the buffer is full is dropped. It sets `overflow`, which stays 1 until reset.
- R9: While the buffer holds entries, a change on `modeStack` has no effect. While the buffer is empty, the order follows `modeStack` in that same cycle.
- R10: A push and a pop in the same cycle both take effect. In stack order, the pushed entry replaces the entry being popped as the new top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeStack | input | 1 | 0 = queue order, 1 = stack order |
| intEnable | input | 1 | Global interrupt enable; replay allowed when 1 |
| pushValid | input | 1 | Flush logic offers an interrupt |
| pushId | input | ID_W | Interrupt identity |
| pushPrio | input | PRIO_W | Interrupt priority, larger is higher |
| pushAddr | input | ADDR_W | Address of the interrupted instruction |
| pushReject | output | 1 | Push refused for priority (stack order) |
| popValid | output | 1 | An entry is offered for replay |
| popReady | input | 1 | Fetch takes the offered entry |
| popId | output | ID_W | Identity of the offered entry |
| popPrio | output | PRIO_W | Priority of the offered entry |
| popAddr | output | ADDR_W | Restart address of the offered entry |
| full | output | 1 | Buffer holds DEPTH entries |
| empty | output | 1 | Buffer holds no entries |
| overflow | output | 1 | Sticky: a push was dropped because the buffer was full |

## Verification
The bench sweeps every pair of priorities in stack order and checks for each pair that a push is refused exactly when its priority does not exceed the top. A design that compared with >= instead of > would accept equal priorities and fail this sweep. It fills the buffer to its limit in both orders and checks the order of replay. A swapped pointer would show up as reversed or repeated entries. It also checks that a full buffer drops the extra push and keeps `overflow` set, and that a priority refusal on a full stack does not count as an overflow. Further checks confirm that a mode change made while entries are held is ignored until the buffer drains, that no entry leaves while `intEnable` is low even with `popReady` high, and that a push and a pop in the same cycle put the new entry on top.

// File: rtl/dib_pkg.sv
package dib_pkg;

  typedef enum logic {
    ORDER_QUEUE = 1'b0,
    ORDER_STACK = 1'b1
  } dibOrder_e;

  // Strobes from the control to the storage datapath.
  typedef struct packed {
    logic wrEn;      // write the push fields this cycle
    logic stackSel;  // read the newest entry instead of the oldest
  } dibStrobe_t;

endpackage

// File: rtl/dib_ctrl.sv
module dib_ctrl
  import dib_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int PRIO_W = 3,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeStack,
  input  logic              intEnable,
  input  logic              pushValid,
  input  logic [PRIO_W-1:0] pushPrio,
  input  logic              popReady,
  input  logic [PRIO_W-1:0] headPrio,
  output dibStrobe_t        strobe,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [IDX_W-1:0]  oldIdx,
  output logic [IDX_W-1:0]  newIdx,
  output logic              pushReject,
  output logic              popValid,
  output logic              full,
  output logic              empty,
  output logic              overflow
);

  function automatic logic [IDX_W-1:0] stepUp(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] stepDown(input logic [IDX_W-1:0] p);
    return (p == '0) ? IDX_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  logic [IDX_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  dibOrder_e        modeReg, modeEff;
  logic             stackMode, prioLow, pushOk, popFire, overflowReg;

  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign modeEff   = empty ? dibOrder_e'(modeStack) : modeReg;
  assign stackMode = (modeEff == ORDER_STACK);

  assign oldIdx = rdPtr;
  assign newIdx = stepDown(wrPtr);

  assign prioLow    = stackMode && !empty && (pushPrio <= headPrio);
  assign pushReject = pushValid && prioLow;
  assign pushOk     = pushValid && !prioLow && !full;
  assign popValid   = intEnable && !empty;
  assign popFire    = popValid && popReady;
  assign overflow   = overflowReg;

  // In stack order a simultaneous pop frees the top slot for the new entry.
  assign wrIdx = (stackMode && popFire) ? newIdx : wrPtr;

  always_comb begin
    strobe          = '0;
    strobe.wrEn     = pushOk;
    strobe.stackSel = stackMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr       <= '0;
      wrPtr       <= '0;
      count       <= '0;
      modeReg     <= ORDER_QUEUE;
      overflowReg <= 1'b0;
    end else begin
      modeReg <= modeEff;
      if (pushValid && !prioLow && full) overflowReg <= 1'b1;
      if (stackMode) begin
        if (pushOk && !popFire)      wrPtr <= stepUp(wrPtr);
        else if (popFire && !pushOk) wrPtr <= stepDown(wrPtr);
      end else begin
        if (pushOk)  wrPtr <= stepUp(wrPtr);
        if (popFire) rdPtr <= stepUp(rdPtr);
      end
      if (pushOk && !popFire)      count <= count + 1'b1;
      else if (popFire && !pushOk) count <= count - 1'b1;
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  assert_single_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (popFire && !pushOk) |=> (count == $past(count) - 1'b1));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflowReg |=> overflowReg);

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !empty |=> $stable(modeReg));

  assert_reject_stores_nothing_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pushReject && !popFire) |=> (count == $past(count)));

endmodule

// File: rtl/dib_store.sv
module dib_store
  import dib_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 5,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dibStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  oldIdx,
  input  logic [IDX_W-1:0]  newIdx,
  input  logic [ID_W-1:0]   inId,
  input  logic [PRIO_W-1:0] inPrio,
  input  logic [ADDR_W-1:0] inAddr,
  output logic [ID_W-1:0]   outId,
  output logic [PRIO_W-1:0] outPrio,
  output logic [ADDR_W-1:0] outAddr
);

  logic [ID_W-1:0]   idMem   [DEPTH];
  logic [PRIO_W-1:0] prioMem [DEPTH];
  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [IDX_W-1:0]  rdIdx;

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idMem[g]   <= '0;
        prioMem[g] <= '0;
        addrMem[g] <= '0;
      end else if (strobe.wrEn && (wrIdx == IDX_W'(g))) begin
        idMem[g]   <= inId;
        prioMem[g] <= inPrio;
        addrMem[g] <= inAddr;
      end
    end
  end

  assign rdIdx   = strobe.stackSel ? newIdx : oldIdx;
  assign outId   = idMem[rdIdx];
  assign outPrio = prioMem[rdIdx];
  assign outAddr = addrMem[rdIdx];

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> (idMem[$past(wrIdx)] == $past(inId)
                     && addrMem[$past(wrIdx)] == $past(inAddr)));

endmodule

// File: rtl/deferred_irq_buffer.sv
module deferred_irq_buffer
  import dib_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 5,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeStack,
  input  logic              intEnable,
  input  logic              pushValid,
  input  logic [ID_W-1:0]   pushId,
  input  logic [PRIO_W-1:0] pushPrio,
  input  logic [ADDR_W-1:0] pushAddr,
  output logic              pushReject,
  output logic              popValid,
  input  logic              popReady,
  output logic [ID_W-1:0]   popId,
  output logic [PRIO_W-1:0] popPrio,
  output logic [ADDR_W-1:0] popAddr,
  output logic              full,
  output logic              empty,
  output logic              overflow
);

  dibStrobe_t       strobe;
  logic [IDX_W-1:0] wrIdx, oldIdx, newIdx;

  dib_ctrl #(.DEPTH(DEPTH), .PRIO_W(PRIO_W)) uCtrl (
    .clk(clk), .rstN(rstN), .modeStack(modeStack), .intEnable(intEnable),
    .pushValid(pushValid), .pushPrio(pushPrio), .popReady(popReady),
    .headPrio(popPrio), .strobe(strobe), .wrIdx(wrIdx), .oldIdx(oldIdx),
    .newIdx(newIdx), .pushReject(pushReject), .popValid(popValid),
    .full(full), .empty(empty), .overflow(overflow)
  );

  dib_store #(.DEPTH(DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .oldIdx(oldIdx),
    .newIdx(newIdx), .inId(pushId), .inPrio(pushPrio), .inAddr(pushAddr),
    .outId(popId), .outPrio(popPrio), .outAddr(popAddr)
  );

  assert_replay_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> (intEnable && !empty));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

endmodule

// File: tb/tb_deferred_irq_buffer.sv
module tb_deferred_irq_buffer;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeStack = 1'b0, intEnable = 1'b0, pushValid = 1'b0, popReady = 1'b0;
  logic [4:0]  pushId = '0;
  logic [2:0]  pushPrio = '0;
  logic [15:0] pushAddr = '0;
  logic        pushReject, popValid, full, empty, overflow;
  logic [4:0]  popId;
  logic [2:0]  popPrio;
  logic [15:0] popAddr;

  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  deferred_irq_buffer dut (
    .clk(clk), .rstN(rstN), .modeStack(modeStack), .intEnable(intEnable),
    .pushValid(pushValid), .pushId(pushId), .pushPrio(pushPrio), .pushAddr(pushAddr),
    .pushReject(pushReject), .popValid(popValid), .popReady(popReady),
    .popId(popId), .popPrio(popPrio), .popAddr(popAddr),
    .full(full), .empty(empty), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] addrOf(input int k);
    return 16'h4000 + 16'(k * 4);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; pushValid = 0; popReady = 0; intEnable = 0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Offer a push; expectReject is checked combinationally before the edge.
  task automatic push(input int id, input int prio, input logic expRej, input string req);
    @(negedge clk);
    pushValid = 1; popReady = 0;
    pushId = 5'(id); pushPrio = 3'(prio); pushAddr = addrOf(id);
    #1 chk(req, 32'(pushReject), 32'(expRej));
  endtask

  // Take one entry and check its fields.
  task automatic pop(input int id, input int prio, input string req);
    @(negedge clk);
    pushValid = 0; popReady = 1; intEnable = 1;
    #1;
    chk(req, 32'(popValid), 1);
    chk(req, 32'(popId), 32'(id));
    chk(req, 32'(popPrio), 32'(prio));
    chk(req, 32'(popAddr), 32'(addrOf(id)));
  endtask

  task automatic idle();
    @(negedge clk);
    pushValid = 0; popReady = 0;
    #1;
  endtask

  initial begin
    // R1 reset state
    #1;
    chk("R1", 32'(empty), 1);
    chk("R1", 32'(full), 0);
    chk("R1", 32'(overflow), 0);
    chk("R1", 32'(popValid), 0);
    chk("R1", 32'(pushReject), 0);
    doReset();

    // R3, R7, R8: queue order fill, overflow, disabled replay, drain
    modeStack = 0;
    for (int k = 0; k < DEPTH; k++) begin
      push(k + 1, DEPTH - k, 0, "R5");
      idle();
      chk("R7", 32'(full), (k == DEPTH - 1) ? 1 : 0);
      chk("R7", 32'(empty), 0);
    end
    push(20, 7, 0, "R5");
    idle();
    chk("R8", 32'(overflow), 1);
    // R6: intEnable low hides entries even with popReady high
    @(negedge clk); intEnable = 0; popReady = 1;
    #1 chk("R6", 32'(popValid), 0);
    idle();
    chk("R6", 32'(full), 1);
    for (int k = 0; k < DEPTH; k++) pop(k + 1, DEPTH - k, "R3");
    idle();
    chk("R7", 32'(empty), 1);
    chk("R6", 32'(popValid), 0);
    chk("R8", 32'(overflow), 1);

    // R4, R5: stack fill with rising priority, refused push on full stack
    doReset();
    modeStack = 1;
    for (int k = 0; k < DEPTH; k++) begin
      push(k + 8, 2 * k + 1, 0, "R5");
    end
    idle();
    chk("R7", 32'(full), 1);
    push(30, 2, 1, "R5");
    idle();
    chk("R8", 32'(overflow), 0);
    for (int k = DEPTH - 1; k >= 0; k--) pop(k + 8, 2 * k + 1, "R4");
    idle();
    chk("R7", 32'(empty), 1);

    // R5 sweep: every priority pair on a stack of one
    for (int p = 0; p < 8; p++) begin
      for (int q = 0; q < 8; q++) begin
        push(1, p, 0, "R5");
        push(2, q, (q <= p) ? 1'b1 : 1'b0, "R5");
        if (q > p) pop(2, q, "R4");
        pop(1, p, "R2");
        idle();
        chk("R7", 32'(empty), 1);
      end
    end

    // R9: mode change while held is ignored, applied once drained
    push(3, 4, 0, "R5");
    push(4, 6, 0, "R5");
    @(negedge clk); pushValid = 0; modeStack = 0;
    push(5, 1, 1, "R9");
    pop(4, 6, "R9");
    pop(3, 4, "R9");
    idle();
    push(6, 5, 0, "R9");
    push(7, 1, 0, "R9");
    pop(6, 5, "R9");
    pop(7, 1, "R9");

    // R10: simultaneous push and pop, queue order
    push(9, 2, 0, "R10");
    @(negedge clk);
    pushValid = 1; popReady = 1; intEnable = 1;
    pushId = 10; pushPrio = 3; pushAddr = addrOf(10);
    #1 chk("R10", 32'(popId), 9);
    pop(10, 3, "R10");
    idle();
    chk("R10", 32'(empty), 1);

    // R10: simultaneous push and pop, stack order replaces the top
    modeStack = 1;
    push(11, 1, 0, "R10");
    push(12, 3, 0, "R10");
    @(negedge clk);
    pushValid = 1; popReady = 1; intEnable = 1;
    pushId = 13; pushPrio = 5; pushAddr = addrOf(13);
    #1 chk("R10", 32'(popId), 12);
    pop(13, 5, "R10");
    pop(11, 1, "R10");
    idle();
    chk("R10", 32'(empty), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule